// File: doc/BRIEF.md
# Serial Wire Debug host engine

This block is the host side of a two-wire debug link. It owns a clock line and a bidirectional data line and runs one register transaction at a time. A caller hands it a request: whether the target register sits in an access port or in the debug port, whether the access reads or writes, a two-bit register address, 32 bits of write data, and a count of idle clocks to insert after an access-port access. The engine sends the 8-bit request header, releases the line so the target can answer, decodes the 3-bit acknowledge, and then moves 32 data bits plus a parity bit in the needed direction. It returns a result code and, for a good read, the read word.

The engine is a six-state machine. `S_IDLE` waits for a request. Accepting one moves it to `S_REQ`, which drives the header. `S_REQ` always goes on to `S_FRAME`, where the line is released: 38 bit times for a read (turnaround, acknowledge, data, parity, turnaround) and 5 for a write (turnaround, acknowledge, turnaround). When `S_FRAME` ends there are four possible moves. A bad acknowledge goes to `S_TAIL`. A good write goes to `S_WDATA`, which drives data and parity. A good access-port access with a non-zero pad count goes to `S_PAD`. Any other case goes to `S_TAIL`. `S_WDATA` leads to `S_PAD` or `S_TAIL` under the same padding rule. `S_PAD` leads to `S_TAIL`. `S_TAIL` drives 8 idle clocks and returns to `S_IDLE` with a one-cycle `done` pulse.

The data line changes while the clock is low and is sampled on the rising clock edge. Each clock phase lasts `DIV` system clocks, so one bit takes `2*DIV` system clocks. When the engine is idle the clock is held low and the data line is driven low.

Top module: `swdh_engine`

## Requirements
- R1: The header goes out least significant bit first, with the output enable high. Its bits are: bit0 start = 1, bit1 access-port select, bit2 read, bits3-4 address (bit 3 holds address bit 0), bit5 = XOR of bits 1 to 4, bit6 = 0, bit7 park = 1.
- R2: In a read, the output enable is low for the 38 bit times that follow the header, and it is low only while `busy` is high.
- R3: In a write with an OK acknowledge, the output enable is low for 5 bit times. The engine then drives the 32 write-data bits least significant first, followed by their XOR parity.
- R4: The acknowledge is taken from the 2nd, 3rd and 4th released bits, the first of them being acknowledge bit 0. 3'b001 is OK, 3'b010 is WAIT and 3'b100 is FAULT. Any other value is a protocol error. Status codes: 0 ok, 1 wait, 2 fault, 3 protocol error, 4 parity error.
- R5: A non-OK acknowledge ends the transaction. A write then skips its data phase, no padding is added, and the tail follows at once.
- R6: On a read with an OK acknowledge, the 37th released bit must equal the XOR of the 32 data bits (released bits 5 to 36). If it does not, the status is 4.
- R7: After an access-port access with an OK acknowledge, the engine adds `req_pad` idle clocks with the data line driven low.
- R8: Every transaction ends with exactly 8 idle clocks driven low. The clock then stays low while `busy` is low.
- R9: Each clock phase lasts `DIV` system clocks, so a bit takes `2*DIV` system clocks. The clock is low when a transaction starts.
- R10: `busy` rises in the cycle after a request is accepted. It falls in the same cycle as the single `done` pulse. A request presented while `busy` is high is ignored.
- R11: `rdata` changes only on a read with an OK acknowledge and good parity. In every other case it keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_ap | input | 1 | 1 = access port, 0 = debug port |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | 2 | Register address bits |
| req_wdata | input | 32 | Write data |
| req_pad | input | PADW | Idle clocks to insert after an access-port access |
| busy | output | 1 | A transaction is in progress |
| done | output | 1 | One-cycle pulse: status is valid |
| status | output | 3 | Result code (R4) |
| rdata | output | 32 | Last good read word |
| swclk | output | 1 | Debug clock line |
| swdio_o | output | 1 | Data line output value |
| swdio_oe | output | 1 | Data line output enable |
| swdio_i | input | 1 | Data line input value |

## Verification
The assertions assume that `rst_n` is low for at least one clock edge before traffic starts. They also assume that the caller pulses `req_valid` for single cycles, and that `swdio_i` only changes while the clock line is low, away from the rising edge at which it is sampled. The bench's target model sets each response bit on a falling clock edge and waits for the next rising edge before it moves on. The driver waits for `busy` to be low before it raises a request. The only exception is one deliberate request made during a transaction, which tests that requests are ignored while busy.

// File: rtl/swdh_pkg.sv
`timescale 1ns/1ps
package swdh_pkg;

    typedef enum logic [2:0] {
        S_IDLE, S_REQ, S_FRAME, S_WDATA, S_PAD, S_TAIL
    } eng_state_t;

    typedef enum logic [2:0] {
        RES_OK     = 3'd0,
        RES_WAIT   = 3'd1,
        RES_FAULT  = 3'd2,
        RES_PROTO  = 3'd3,
        RES_PARITY = 3'd4
    } result_t;

    localparam int HDR_BITS  = 8;
    localparam int RD_FRAME  = 38;
    localparam int WR_FRAME  = 5;
    localparam int DATA_BITS = 33;
    localparam int TAIL_CLKS = 8;

    // Header: start, port select, read, addr[1:0], even parity, stop, park
    function automatic logic [7:0] build_hdr(logic ap, logic rd, logic [1:0] addr);
        return {1'b1, 1'b0, ap ^ rd ^ addr[0] ^ addr[1], addr[1], addr[0], rd, ap, 1'b1};
    endfunction

endpackage

// File: rtl/swdh_tick.sv
`timescale 1ns/1ps
module swdh_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic rise,
    output logic fall
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;
    logic          high_q;
    logic          wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            high_q <= 1'b0;
        end else if (!run) begin
            cnt_q  <= '0;
            high_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            high_q <= ~high_q;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign wrap = run && (cnt_q == LAST);
    assign rise = wrap && !high_q;
    assign fall = wrap && high_q;
endmodule

// File: rtl/swdh_resp_eval.sv
`timescale 1ns/1ps
module swdh_resp_eval
    import swdh_pkg::*;
(
    input  logic [2:0]  ack,
    input  logic [31:0] data,
    input  logic        par,
    output logic        ack_ok,
    output logic        par_ok,
    output logic [2:0]  ack_res
);
    always_comb begin
        unique case (ack)
            3'b001:  ack_res = RES_OK;
            3'b010:  ack_res = RES_WAIT;
            3'b100:  ack_res = RES_FAULT;
            default: ack_res = RES_PROTO;
        endcase
    end

    assign ack_ok = (ack == 3'b001);
    assign par_ok = (par == ^data);
endmodule

// File: rtl/swdh_engine.sv
`timescale 1ns/1ps
module swdh_engine
    import swdh_pkg::*;
#(
    parameter int DIV  = 2,
    parameter int PADW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_ap,
    input  logic            req_read,
    input  logic [1:0]      req_addr,
    input  logic [31:0]     req_wdata,
    input  logic [PADW-1:0] req_pad,
    output logic            busy,
    output logic            done,
    output logic [2:0]      status,
    output logic [31:0]     rdata,
    output logic            swclk,
    output logic            swdio_o,
    output logic            swdio_oe,
    input  logic            swdio_i
);
    localparam int BW = (PADW > 6) ? PADW : 6;

    eng_state_t      state_q, state_d;
    logic [BW-1:0]   bit_q, last_q;
    logic [32:0]     sh_q;
    logic [36:1]     rx_q;
    logic            ap_q, rd_q;
    logic [PADW-1:0] pad_q;
    logic [31:0]     wdata_q, rdata_q;
    logic [2:0]      status_q;
    logic            done_q, swclk_q;
    logic            rise, fall, phase_end;
    logic            ack_ok, par_ok;
    logic [2:0]      ack_res;
    logic [5:0]      rx_idx;
    eng_state_t      after_data;

    swdh_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (state_q != S_IDLE),
        .rise (rise),
        .fall (fall)
    );

    swdh_resp_eval u_resp (
        .ack    (rx_q[3:1]),
        .data   (rx_q[35:4]),
        .par    (rx_q[36]),
        .ack_ok (ack_ok),
        .par_ok (par_ok),
        .ack_res(ack_res)
    );

    assign phase_end  = fall && (bit_q == last_q);
    assign after_data = (ap_q && (pad_q != '0)) ? S_PAD : S_TAIL;
    assign rx_idx     = bit_q[5:0];

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (req_valid) state_d = S_REQ;
            S_REQ:   if (phase_end) state_d = S_FRAME;
            S_FRAME: if (phase_end) begin
                         if (!ack_ok)    state_d = S_TAIL;
                         else if (!rd_q) state_d = S_WDATA;
                         else            state_d = after_data;
                     end
            S_WDATA: if (phase_end) state_d = after_data;
            S_PAD:   if (phase_end) state_d = S_TAIL;
            S_TAIL:  if (phase_end) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            bit_q    <= '0;
            last_q   <= '0;
            sh_q     <= '0;
            rx_q     <= '0;
            ap_q     <= 1'b0;
            rd_q     <= 1'b0;
            pad_q    <= '0;
            wdata_q  <= '0;
            rdata_q  <= '0;
            status_q <= RES_OK;
            done_q   <= 1'b0;
            swclk_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= 1'b0;
            if (rise) begin
                swclk_q <= 1'b1;
                if (state_q == S_FRAME && rx_idx >= 6'd1 && rx_idx <= 6'd36)
                    rx_q[rx_idx] <= swdio_i;
            end
            if (fall) swclk_q <= 1'b0;

            if (state_q == S_IDLE && req_valid) begin
                ap_q    <= req_ap;
                rd_q    <= req_read;
                pad_q   <= req_pad;
                wdata_q <= req_wdata;
                sh_q    <= {25'b0, build_hdr(req_ap, req_read, req_addr)};
            end
            if (state_d == S_WDATA && state_q != S_WDATA)
                sh_q <= {^wdata_q, wdata_q};
            if (state_d != state_q) begin
                bit_q <= '0;
                unique case (state_d)
                    S_REQ:   last_q <= BW'(HDR_BITS - 1);
                    S_FRAME: last_q <= rd_q ? BW'(RD_FRAME - 1) : BW'(WR_FRAME - 1);
                    S_WDATA: last_q <= BW'(DATA_BITS - 1);
                    S_PAD:   last_q <= BW'(pad_q) - BW'(1);
                    S_TAIL:  last_q <= BW'(TAIL_CLKS - 1);
                    default: last_q <= '0;
                endcase
                if (state_d == S_IDLE) done_q <= 1'b1;
            end else if (fall && !(state_d == S_WDATA && state_q != S_WDATA)) begin
                bit_q <= bit_q + BW'(1);
                sh_q  <= sh_q >> 1;
            end

            if (state_q == S_FRAME && phase_end) begin
                if (!ack_ok)              status_q <= ack_res;
                else if (rd_q && !par_ok) status_q <= RES_PARITY;
                else                      status_q <= RES_OK;
                if (ack_ok && rd_q && par_ok) rdata_q <= rx_q[35:4];
            end
        end
    end

    // Outputs
    always_comb begin
        busy     = (state_q != S_IDLE);
        done     = done_q;
        status   = status_q;
        rdata    = rdata_q;
        swclk    = swclk_q;
        swdio_oe = (state_q != S_FRAME);
        swdio_o  = (state_q == S_REQ || state_q == S_WDATA) ? sh_q[0] : 1'b0;
    end
endmodule

// File: rtl/swdh_checks.sv
`timescale 1ns/1ps
module swdh_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        done,
    input logic        swclk,
    input logic        swdio_oe,
    input logic [2:0]  status,
    input logic [31:0] rdata
);
    AST_CLK_LOW_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !swclk);              // R8
    AST_RELEASE_BUSY:   assert property (@(posedge clk) disable iff (!rst_n) !swdio_oe |-> busy);            // R2
    AST_CLK_LOW_START:  assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> !swclk);        // R9
    AST_DONE_CLOSES:    assert property (@(posedge clk) disable iff (!rst_n) done |-> (!busy && $past(busy))); // R10
    AST_STATUS_HELD:    assert property (@(posedge clk) disable iff (!rst_n) !busy |=> $stable(status));     // R10
    AST_RDATA_HELD:     assert property (@(posedge clk) disable iff (!rst_n) !busy |=> $stable(rdata));      // R11
endmodule

bind swdh_engine swdh_checks i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .swclk   (swclk),
    .swdio_oe(swdio_oe),
    .status  (status),
    .rdata   (rdata)
);

// File: tb/test_swdh_engine.sv
`timescale 1ns/1ps
module test_swdh_engine;
    localparam int DIV  = 2;
    localparam int PADW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ap = 1'b0, req_read = 1'b0;
    logic [1:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [PADW-1:0] req_pad = '0;
    logic busy, done, swclk, swdio_o, swdio_oe;
    logic swdio_i = 1'b0;
    logic [2:0] status;
    logic [31:0] rdata;

    int checks = 0, fails = 0;

    swdh_engine #(.DIV(DIV), .PADW(PADW)) i_swdh_engine (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ap(req_ap),
        .req_read(req_read), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_pad(req_pad), .busy(busy), .done(done), .status(status),
        .rdata(rdata), .swclk(swclk), .swdio_o(swdio_o), .swdio_oe(swdio_oe),
        .swdio_i(swdio_i)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic [7:0]  hdr;
        logic [31:0] wd;
        logic        has_wd;
        logic [2:0]  st;
        logic [31:0] rd;
        int          idle;
        string       tag;
        string       idle_tag;
    } exp_t;
    exp_t sb[$];

    // Target model controls and captures
    logic [2:0]  tgt_ack;
    logic [31:0] tgt_word;
    logic        tgt_badpar, tgt_rd;
    logic [7:0]  cap_hdr;
    logic [32:0] cap_w;
    int          cap_idle, oe_err;
    time         t0, t1;
    logic [31:0] model_rdata = '0;

    task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Target: answers on the line, records what the host drove
    initial begin
        forever begin
            logic [37:0] fb;
            logic        running;
            @(posedge busy);
            oe_err = 0;
            for (int i = 0; i < 8; i++) begin
                @(posedge swclk);
                if (i == 0) t0 = $time;
                if (i == 1) t1 = $time;
                cap_hdr[i] = swdio_o;
                if (!swdio_oe) oe_err++;
            end
            fb = '0;
            fb[3:1]  = tgt_ack;
            fb[35:4] = tgt_word;
            fb[36]   = (^tgt_word) ^ tgt_badpar;
            for (int k = 0; k < (tgt_rd ? 38 : 5); k++) begin
                @(negedge swclk);
                swdio_i = fb[k];
                @(posedge swclk);
                if (swdio_oe) oe_err++;
            end
            if (!tgt_rd && tgt_ack == 3'b001) begin
                for (int j = 0; j < 33; j++) begin
                    @(posedge swclk);
                    cap_w[j] = swdio_o;
                    if (!swdio_oe) oe_err++;
                end
            end
            cap_idle = 0;
            running  = 1'b1;
            while (running) begin
                @(posedge swclk or negedge busy);
                if (!busy) running = 1'b0;
                else begin
                    cap_idle++;
                    if (!swdio_oe || swdio_o) oe_err++;
                end
            end
        end
    end

    // Monitor: pops the scoreboard on every done pulse
    initial begin
        forever begin
            @(negedge clk);
            if (done) begin
                if (sb.size() == 0) chk(1'b0, "R10 unexpected done", 1, 0);
                else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(status == e.st, e.tag, 64'(status), 64'(e.st));
                    chk(rdata == e.rd, "R11 rdata", 64'(rdata), 64'(e.rd));
                    chk(cap_hdr == e.hdr, "R1 header", 64'(cap_hdr), 64'(e.hdr));
                    chk(cap_idle == e.idle, e.idle_tag, 64'(cap_idle), 64'(e.idle));
                    chk(oe_err == 0, "R2/R3 line direction", 64'(oe_err), 0);
                    chk((t1 - t0) == time'(2 * DIV * 8), "R9 bit period", 64'(t1 - t0), 64'(2 * DIV * 8));
                    if (e.has_wd)
                        chk(cap_w == {^e.wd, e.wd}, "R3 write data", 64'(cap_w), 64'({^e.wd, e.wd}));
                end
            end
        end
    end

    task automatic do_txn(input logic ap, input logic rd, input logic [1:0] addr,
                          input logic [31:0] wd, input logic [PADW-1:0] pad,
                          input logic [2:0] ack, input logic [31:0] word,
                          input logic badpar, input string tag, input logic poke);
        exp_t e;
        logic ok;
        ok = (ack == 3'b001);
        e.hdr    = {1'b1, 1'b0, ap ^ rd ^ addr[0] ^ addr[1], addr[1], addr[0], rd, ap, 1'b1};
        e.wd     = wd;
        e.has_wd = ok && !rd;
        case (ack)
            3'b001:  e.st = (rd && badpar) ? 3'd4 : 3'd0;
            3'b010:  e.st = 3'd1;
            3'b100:  e.st = 3'd2;
            default: e.st = 3'd3;
        endcase
        if (ok && rd && !badpar) model_rdata = word;
        e.rd       = model_rdata;
        e.idle     = (ok && ap) ? int'(pad) + 8 : 8;
        e.idle_tag = (ok && ap) ? "R7 pad+tail clocks" : "R8 tail clocks";
        e.tag      = tag;
        sb.push_back(e);
        tgt_ack = ack; tgt_word = word; tgt_badpar = badpar; tgt_rd = rd;
        @(negedge clk);
        while (busy) @(negedge clk);
        req_ap = ap; req_read = rd; req_addr = addr; req_wdata = wd; req_pad = pad;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            repeat (6) @(negedge clk);
            req_ap = 1'b1; req_read = 1'b0; req_addr = 2'b11; req_wdata = 32'hFFFF_FFFF;
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0,     "R10 reset busy",  64'(busy), 0);
        chk(swclk == 1'b0,    "R8 reset clock",  64'(swclk), 0);
        chk(swdio_oe == 1'b1, "R2 reset drive",  64'(swdio_oe), 1);
        chk(rdata == '0,      "R11 reset rdata", 64'(rdata), 0);
        chk(status == 3'd0,   "R4 reset status", 64'(status), 0);

        do_txn(1'b0, 1'b1, 2'd0, 32'h0,         8'd0, 3'b001, 32'h1234_5678, 1'b0, "R4 dp read ok", 1'b0);
        do_txn(1'b0, 1'b0, 2'd1, 32'hA5A5_0F0F, 8'd0, 3'b001, 32'h0,         1'b0, "R3 dp write ok", 1'b0);
        do_txn(1'b1, 1'b1, 2'd3, 32'h0,         8'd5, 3'b001, 32'h8000_0001, 1'b0, "R7 ap read pad", 1'b0);
        do_txn(1'b1, 1'b0, 2'd2, 32'h0000_0007, 8'd3, 3'b001, 32'h0,         1'b0, "R7 ap write pad", 1'b0);
        do_txn(1'b0, 1'b1, 2'd2, 32'h0,         8'd0, 3'b010, 32'hDEAD_BEEF, 1'b0, "R5 read wait", 1'b0);
        do_txn(1'b1, 1'b0, 2'd1, 32'h1111_2222, 8'd4, 3'b100, 32'h0,         1'b0, "R5 ap write fault", 1'b0);
        do_txn(1'b0, 1'b1, 2'd1, 32'h0,         8'd0, 3'b111, 32'hCAFE_F00D, 1'b0, "R4 ack 111 protocol", 1'b0);
        do_txn(1'b1, 1'b1, 2'd0, 32'h0,         8'd2, 3'b000, 32'h0BAD_0BAD, 1'b0, "R4 ack 000 protocol", 1'b0);
        do_txn(1'b0, 1'b1, 2'd3, 32'h0,         8'd0, 3'b001, 32'h7654_3210, 1'b1, "R6 parity error", 1'b0);
        do_txn(1'b1, 1'b1, 2'd1, 32'h0,         8'd0, 3'b001, 32'hFFFF_0000, 1'b0, "R8 ap read no pad", 1'b0);
        do_txn(1'b0, 1'b0, 2'd0, 32'h8000_0000, 8'd0, 3'b001, 32'h0,         1'b0, "R10 write poked", 1'b1);

        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (busy) begin
                chk(1'b0, "R10 request while busy started a transaction", 1, 0);
                break;
            end
        end
        chk(sb.size() == 0, "R10 all results seen", 64'(sb.size()), 0);
        chk(swclk == 1'b0, "R8 clock low when idle", 64'(swclk), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule